// File: doc/BRIEF.md
# Serial-Priority Bus Arbiter

This block decides which of several devices may use a shared bus. Each device has a local request. All local requests are merged into one bus request line. A central controller watches only that merged line. When it sees the line high while the bus is free, it raises a single grant. The grant enters the device chain at position 0.

Each device cell either keeps the grant, if it is requesting, or hands it on to the next cell. Priority therefore comes only from position: index 0 ranks highest and index NDEV-1 ranks lowest. The cell that keeps the grant becomes the bus owner on the next cycle. It stays owner until it raises its done input, which drives the shared release line. The controller then withholds the grant for a cooldown cycle and samples the merged request again.

No fairness is provided. A device that requests continuously at a high position can shut out lower devices indefinitely. The block has no data path, so no valid/ready stream interface applies, and every pin is a plain control level.

Top module: `daisy_arbiter`

## Requirements
- R1: While rst_n is low and after reset, bus_grant, bus_release and owner are all 0.
- R2: bus_req equals the OR of all bits of dev_req in the same cycle.
- R3: When the bus is free and bus_req is high at a clock edge, bus_grant is 1 for the following cycle.
- R4: While bus_grant is 1, the requesting device with the lowest index keeps it. On the next cycle `owner` is one-hot on that index, with bit i meaning device i.
- R5: A device that is not requesting passes the grant onward. A gap of idle devices before the first requester does not change who wins.
- R6: At most one bit of `owner` is ever set.
- R7: While a device owns the bus, bus_grant stays 0 and ownership is unchanged. dev_done from a device that does not own the bus has no effect.
- R8: bus_release is 1 exactly when the owner's dev_done bit is 1. On the next cycle `owner` is 0. bus_grant then stays 0 for that cycle and for one further cycle, before the request line is sampled again.
- R9: A device at index 0 that keeps requesting wins every arbitration, and a lower device that is also requesting never becomes owner.
- R10: If no device is requesting while bus_grant is 1, the grant leaves the end of the chain unused. The bus returns to free with `owner` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NDEV | Per-device request level |
| dev_done | input | NDEV | Per-device completion level, honoured only from the owner |
| bus_req | output | 1 | Merged request line seen by the controller |
| bus_grant | output | 1 | Grant driven into the chain at device 0 |
| bus_release | output | 1 | Shared release line, high while the owner signals done |
| owner | output | NDEV | One-hot bus ownership, bit i = device i |

## Verification
The bench builds the block with NDEV = 4. Four positions are enough to set up gaps of non-requesting devices both ahead of and behind the winner. With four positions the grant can also run off the far end of the chain. The same width lets device 0 and device 1 compete over repeated rounds, so that the starvation of the lower device can be observed.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  typedef enum logic [1:0] {
    ARB_FREE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_HELD  = 2'd2,
    ARB_COOL  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/daisy_link.sv
module daisy_link (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic done,
  input  logic gnt_in,
  output logic gnt_out,
  output logic take,
  output logic owned,
  output logic rel
);
  assign take    = req & gnt_in;
  assign gnt_out = gnt_in & ~req;
  assign rel     = owned & done;

  always_ff @(posedge clk) begin
    if (!rst_n)    owned <= 1'b0;
    else if (rel)  owned <= 1'b0;
    else if (take) owned <= 1'b1;
  end

  // R7
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !done) |=> owned);
  // R8
  drop_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel |=> !owned);
endmodule

// File: rtl/daisy_ctrl.sv
module daisy_ctrl
  import daisy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic taken,
  input  logic release_i,
  output logic grant
);
  arb_state_t state, state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      ARB_FREE:  if (any_req)   state_n = ARB_OFFER;
      ARB_OFFER: state_n = taken ? ARB_HELD : ARB_FREE;
      ARB_HELD:  if (release_i) state_n = ARB_COOL;
      ARB_COOL:  state_n = ARB_FREE;
      default:   state_n = ARB_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ARB_FREE;
    else        state <= state_n;
  end

  assign grant = (state == ARB_OFFER);

  // R3
  grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ARB_FREE && any_req) |=> grant);
  // R8
  cooldown_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i) |-> !grant);
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  input  logic [NDEV-1:0] dev_done,
  output logic            bus_req,
  output logic            bus_grant,
  output logic            bus_release,
  output logic [NDEV-1:0] owner
);
  localparam int LINKS = NDEV + 1;

  logic [LINKS-1:0] chain;
  logic [NDEV-1:0]  take_v;
  logic [NDEV-1:0]  rel_v;

  assign bus_req     = |dev_req;
  assign bus_release = |rel_v;
  assign chain[0]    = bus_grant;

  genvar i;
  generate
    for (i = 0; i < NDEV; i++) begin : g_link
      daisy_link u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (dev_req[i]),
        .done    (dev_done[i]),
        .gnt_in  (chain[i]),
        .gnt_out (chain[i+1]),
        .take    (take_v[i]),
        .owned   (owner[i]),
        .rel     (rel_v[i])
      );
    end
  endgenerate

  daisy_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_req   (bus_req),
    .taken     (|take_v),
    .release_i (bus_release),
    .grant     (bus_grant)
  );

  // R6
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));
  // R4
  owner_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(owner) == '0 && owner != '0) |-> $past(bus_grant));
  // R7
  no_grant_while_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != '0) |-> !bus_grant);
endmodule

// File: tb/sim_daisy_arbiter.sv
module sim_daisy_arbiter;
  localparam int N = 4;
  localparam time TCLK = 10ns;
  localparam int NV = 6;
  localparam logic [N-1:0] VREQ [NV] = '{4'b0001, 4'b1010, 4'b1100, 4'b1000, 4'b1111, 4'b0110};
  localparam logic [N-1:0] VOWN [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001, 4'b0010};

  logic clk = 0, rst_n = 0;
  logic [N-1:0] dev_req = '0, dev_done = '0;
  logic bus_req, bus_grant, bus_release;
  logic [N-1:0] owner;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(TCLK/2) clk = ~clk;

  daisy_arbiter #(.NDEV(N)) u0 (.clk(clk), .rst_n(rst_n), .dev_req(dev_req),
    .dev_done(dev_done), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_release(bus_release), .owner(owner));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic round(logic [N-1:0] rq, logic [N-1:0] win);
    @(negedge clk); dev_req = rq; #1;
    chk("R2 bus_req", bus_req, 1);
    @(negedge clk);
    chk("R3 grant", bus_grant, 1); chk("R3 no owner yet", owner, 0);
    @(negedge clk);
    chk("R4/R5 owner", owner, win); chk("R7 grant low", bus_grant, 0);
    dev_done = ~win; #1;
    chk("R7 foreign done no release", bus_release, 0);
    @(negedge clk);
    chk("R7 owner kept", owner, win);
    dev_done = win; dev_req = '0; #1;
    chk("R8 release", bus_release, 1);
    @(negedge clk); dev_done = '0;
    chk("R8 owner cleared", owner, 0); chk("R8 grant held off", bus_grant, 0);
    @(negedge clk);
    chk("R8 grant still off", bus_grant, 0);
  endtask

  initial begin
    #(TCLK*5000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 grant", bus_grant, 0); chk("R1 release", bus_release, 0); chk("R1 owner", owner, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 owner after reset", owner, 0);
    for (int v = 0; v < NV; v++) round(VREQ[v], VOWN[v]);

    // R10: request withdrawn while the grant is offered
    @(negedge clk); dev_req = 4'b0100;
    @(negedge clk); chk("R10 grant", bus_grant, 1); dev_req = '0;
    @(negedge clk); chk("R10 no owner", owner, 0); chk("R10 grant gone", bus_grant, 0);
    @(negedge clk); chk("R10 still free", owner, 0);

    // R9: device 0 keeps requesting, device 1 starves
    @(negedge clk); dev_req = 4'b0011;
    @(negedge clk); @(negedge clk);
    chk("R9 first owner", owner, 4'b0001);
    for (int r = 0; r < 4; r++) begin
      dev_done = 4'b0001;
      @(negedge clk); dev_done = '0;
      chk("R9/R8 cleared", owner, 0); chk("R8 cool grant", bus_grant, 0);
      @(negedge clk); chk("R8 free grant", bus_grant, 0);
      @(negedge clk); chk("R3 regrant", bus_grant, 1);
      @(negedge clk); chk("R9 dev0 wins again", owner, 4'b0001);
    end
    dev_req = '0; dev_done = 4'b0001;
    @(negedge clk); dev_done = '0;
    @(negedge clk);
    chk("R9 end free", owner, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule